// File: doc/BRIEF.md
# Lane Frame Aligner with Payload Snapshot

This block sits after a deserializer on one serial lane. Each word it receives holds 66 raw bits: a 2-bit sync header followed by 64 payload bits. The word boundary may not match the real frame boundary. While it hunts for alignment, the block checks each header. When a checked header is illegal it pulses a slip request, and the upstream gearbox then moves its word boundary by one bit. Once enough legal headers arrive in a row, the block declares lock. After lock it counts illegal headers inside fixed windows of frames and drops lock when too many appear.

Header legality alone does not prove that real data is flowing. A free-running 0011 square wave shifts its phase by two bits per 66-bit frame, so at a suitable offset every header reads 01 or 10. To expose this case, the block holds a one-shot snapshot. Software pulses an arm strobe. The block then stores the payloads of the first few consecutive frames it accepts while locked and raises a done flag. Software reads the stored words back through an index. A periodic pattern in those words shows that the lock is false.

The word input is a valid/ready stream. Ready is held high at all times, so the block never applies back-pressure. A word is consumed in every cycle where valid is high, and a cycle with valid low has no effect on any state.

Top module: `lane_align_capture`

## Requirements
- R1: The sync header is `in_word[65:64]` and the payload is `in_word[63:0]`. Headers 01 and 10 are legal. Headers 00 and 11 are illegal.
- R2: While hunting, lock (`locked`=1) is raised in the cycle after the LOCK_RUN-th consecutive checked legal header.
- R3: While hunting, a checked illegal header produces a `slip` pulse of exactly one cycle in the next cycle, and it restarts the count of legal headers from zero.
- R4: After a slip, the next BLANK_LEN accepted frames are not checked. An illegal header among them causes no slip and does not count toward lock.
- R5: While locked, frames are grouped into consecutive windows of WIN_LEN accepted frames, starting at lock. Lock drops in the cycle after the BAD_LIMIT-th illegal header within one window, and hunting then restarts with no blanking.
- R6: While locked, fewer than BAD_LIMIT illegal headers in a window leave lock asserted, and the illegal count restarts at each window boundary.
- R7: `in_ready` is always 1. A cycle with `in_valid`=0 changes neither the lock state, the header run, the slip output nor the snapshot.
- R8: A pulse on `arm` clears `cap_done`. The payloads of the next CAP_DEPTH consecutive frames accepted while locked are then stored into slots 0 and upward, and `cap_done` rises in the cycle after the last of them.
- R9: The stored words stay unchanged, and `cap_done` stays set, until the next `arm`. `cap_word` shows slot `rd_idx` combinationally. Reset clears `locked`, `slip` and `cap_done`.
- R10: A 0011 square wave on the lane can reach lock. The snapshot then holds words with a period of four bits, and a pseudo-random framed stream locks only at the true frame offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word stream valid |
| in_ready | output | 1 | Word stream ready, held at 1 |
| in_word | input | 66 | Header in [65:64], payload in [63:0] |
| arm | input | 1 | Starts a new snapshot |
| rd_idx | input | $clog2(CAP_DEPTH) | Snapshot slot to read |
| locked | output | 1 | Frame alignment achieved |
| slip | output | 1 | One-cycle request to shift the word boundary by one bit |
| cap_done | output | 1 | Snapshot complete |
| cap_word | output | 64 | Payload stored in slot `rd_idx` |

## Verification
The bench builds the block with LOCK_RUN=16, BAD_LIMIT=4, WIN_LEN=16, BLANK_LEN=4 and CAP_DEPTH=3. With these values the directed sequences can reach the exact lock threshold, a full window boundary, a loss of lock and the end of blanking in a few dozen frames. The smaller lock run still makes a false lock at a wrong bit offset unlikely for pseudo-random data. A bench gearbox model then applies the slip requests to a bit stream. This lets the square-wave case and the true-offset search run over many slips within a short run.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam int HDR_W   = 2;
  localparam int PAY_W   = 64;
  localparam int FRAME_W = HDR_W + PAY_W;

  typedef enum logic {ST_HUNT, ST_LOCKED} align_state_e;

  function automatic logic hdr_is_legal(input logic [HDR_W-1:0] hdr);
    return hdr[1] ^ hdr[0];
  endfunction
endpackage

// File: rtl/hdr_lock_fsm.sv
module hdr_lock_fsm #(
  parameter int LOCK_RUN  = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_LEN   = 64,
  parameter int BLANK_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_vld,
  input  logic hdr_ok,
  output logic locked,
  output logic slip
);
  import lane_align_pkg::*;

  localparam int RUN_W   = $clog2(LOCK_RUN + 1);
  localparam int BAD_W   = $clog2(BAD_LIMIT + 1);
  localparam int WIN_W   = $clog2(WIN_LEN + 1);
  localparam int BLANK_W = $clog2(BLANK_LEN + 1);

  align_state_e     state;
  logic [RUN_W-1:0] run_cnt;
  logic [BAD_W-1:0] bad_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic [BLANK_W-1:0] blank_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      run_cnt   <= '0;
      bad_cnt   <= '0;
      win_cnt   <= '0;
      blank_cnt <= '0;
      slip      <= 1'b0;
    end else begin
      slip <= 1'b0;
      if (frame_vld) begin
        unique case (state)
          ST_HUNT: begin
            if (blank_cnt != '0) begin
              blank_cnt <= blank_cnt - 1'b1;
            end else if (hdr_ok) begin
              if (run_cnt == RUN_W'(LOCK_RUN - 1)) begin
                state   <= ST_LOCKED;
                run_cnt <= '0;
                win_cnt <= '0;
                bad_cnt <= '0;
              end else begin
                run_cnt <= run_cnt + 1'b1;
              end
            end else begin
              run_cnt   <= '0;
              slip      <= 1'b1;
              blank_cnt <= BLANK_W'(BLANK_LEN);
            end
          end
          ST_LOCKED: begin
            if (!hdr_ok && bad_cnt == BAD_W'(BAD_LIMIT - 1)) begin
              state   <= ST_HUNT;
              bad_cnt <= '0;
              win_cnt <= '0;
            end else if (win_cnt == WIN_W'(WIN_LEN - 1)) begin
              win_cnt <= '0;
              bad_cnt <= '0;
            end else begin
              win_cnt <= win_cnt + 1'b1;
              bad_cnt <= bad_cnt + BAD_W'(!hdr_ok);
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign locked = (state == ST_LOCKED);

  // R3: a slip request lasts a single cycle
  p_slip_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !slip);

  // R3: slip only follows an accepted frame seen while hunting
  p_slip_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip |-> $past(frame_vld && !locked && !hdr_ok));

  // R5: no slip is requested while aligned
  p_no_slip_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !slip);

  // R7: lock changes only on an accepted frame
  p_lock_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(frame_vld));

  // R2: lock is entered only on a legal header
  p_lock_on_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hdr_ok));
endmodule

// File: rtl/frame_capture.sv
module frame_capture #(
  parameter int DEPTH = 3,
  parameter int PAY_W = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             frame_vld,
  input  logic             locked,
  input  logic [PAY_W-1:0] payload,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             cap_done,
  output logic [PAY_W-1:0] cap_word
);
  logic             armed;
  logic [IDX_W-1:0] fill;
  logic             take;
  logic [PAY_W-1:0] slot [DEPTH];

  assign take = armed && !arm && locked && frame_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cap_done <= 1'b0;
      fill     <= '0;
    end else if (arm) begin
      armed    <= 1'b1;
      cap_done <= 1'b0;
      fill     <= '0;
    end else if (armed) begin
      if (!locked) begin
        fill <= '0;
      end else if (frame_vld) begin
        if (fill == IDX_W'(DEPTH - 1)) begin
          armed    <= 1'b0;
          cap_done <= 1'b1;
          fill     <= '0;
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (take && fill == IDX_W'(g)) begin
        slot[g] <= payload;
      end
    end
  end

  always_comb begin
    cap_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) cap_word = slot[i];
    end
  end

  // R8: completion only after a frame accepted while aligned
  p_done_after_locked_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_done) |-> $past(locked && frame_vld));

  // R9: completion holds until a new arm
  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !arm) |=> cap_done);

  // R8: arming clears completion on the next cycle
  p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !cap_done);

  // R9: a finished snapshot is not rewritten while the index is steady
  p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && $past(cap_done) && $stable(rd_idx)) |-> $stable(cap_word));
endmodule

// File: rtl/lane_align_capture.sv
module lane_align_capture #(
  parameter int LOCK_RUN  = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_LEN   = 64,
  parameter int BLANK_LEN = 32,
  parameter int CAP_DEPTH = 3,
  localparam int IDX_W = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [lane_align_pkg::FRAME_W-1:0]  in_word,
  input  logic                                arm,
  input  logic [IDX_W-1:0]                    rd_idx,
  output logic                                locked,
  output logic                                slip,
  output logic                                cap_done,
  output logic [lane_align_pkg::PAY_W-1:0]    cap_word
);
  import lane_align_pkg::*;

  logic             frame_vld;
  logic             hdr_ok;
  logic [PAY_W-1:0] payload;

  assign in_ready  = 1'b1;
  assign frame_vld = in_valid && in_ready;
  assign hdr_ok    = hdr_is_legal(in_word[FRAME_W-1 -: HDR_W]);
  assign payload   = in_word[PAY_W-1:0];

  hdr_lock_fsm #(
    .LOCK_RUN (LOCK_RUN),
    .BAD_LIMIT(BAD_LIMIT),
    .WIN_LEN  (WIN_LEN),
    .BLANK_LEN(BLANK_LEN)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_vld(frame_vld),
    .hdr_ok   (hdr_ok),
    .locked   (locked),
    .slip     (slip)
  );

  frame_capture #(
    .DEPTH(CAP_DEPTH),
    .PAY_W(PAY_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .frame_vld(frame_vld),
    .locked   (locked),
    .payload  (payload),
    .rd_idx   (rd_idx),
    .cap_done (cap_done),
    .cap_word (cap_word)
  );

  // R7: an idle cycle leaves the slip output quiet on the next edge
  p_idle_no_slip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !slip);
endmodule

// File: tb/test_lane_align_capture.sv
module test_lane_align_capture;
  localparam int LR = 16, BL = 4, WL = 16, BK = 4, CD = 3;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, arm = 1'b0;
  logic [65:0] in_word = '0;
  logic [1:0]  rd_idx = '0;
  logic in_ready, locked, slip, cap_done;
  logic [63:0] cap_word;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  lane_align_capture #(.LOCK_RUN(LR), .BAD_LIMIT(BL), .WIN_LEN(WL),
    .BLANK_LEN(BK), .CAP_DEPTH(CD)) i_lane_align_capture (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .arm(arm), .rd_idx(rd_idx), .locked(locked),
    .slip(slip), .cap_done(cap_done), .cap_word(cap_word));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input longint unsigned x);
    logic [31:0] h;
    h = 32'(x) * 32'h9E3779B1 ^ 32'(x >> 32);
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    return h ^ (h >> 13);
  endfunction

  function automatic logic good_bit(input longint unsigned n);
    longint unsigned f = n / 66, p = n % 66;
    if (p == 0) return mix(f)[0];
    if (p == 1) return ~mix(f)[0];
    return mix(f * 131 + p)[7];
  endfunction

  function automatic logic [65:0] lane_word(input bit square, input longint unsigned k,
                                            input longint unsigned off);
    logic [65:0] w;
    for (int i = 0; i < 66; i++) begin
      longint unsigned n = k * 66 + off + longint'(i);
      w[65-i] = square ? ((n % 4) >= 2) : good_bit(n);
    end
    return w;
  endfunction

  function automatic logic is_square(input logic [63:0] w);
    return (w == {16{w[3:0]}}) && (w[3:0] inside {4'h3, 4'h6, 4'hC, 4'h9});
  endfunction

  function automatic logic [65:0] mk(input logic [1:0] h, input logic [63:0] p);
    return {h, p};
  endfunction

  task automatic step(input logic v, input logic [65:0] w, input logic a);
    in_valid = v; in_word = w; arm = a;
    @(negedge clk);
    in_valid = 1'b0; arm = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [1:0] good_hdr(input int i);
    return i[0] ? 2'b10 : 2'b01;
  endfunction

  task automatic gear_run(input bit square, input string req);
    longint unsigned k = 0, off = 0;
    int ncap = 0, cyc = 0;
    logic [63:0] exp_w [CD];
    logic lk;
    logic [65:0] w;
    do_reset();
    step(1'b0, '0, 1'b1);
    while (!cap_done && cyc < 30000) begin
      logic v = ($urandom % 5) != 0;
      lk = locked;
      w = lane_word(square, k, off);
      step(v, w, 1'b0);
      if (v) begin
        if (lk && ncap < CD) begin exp_w[ncap] = w[63:0]; ncap++; end
        k++;
      end
      if (slip) off++;
      cyc++;
    end
    check({req, " snapshot done"}, 64'(cap_done), 64'd1);
    check({req, " locked"}, 64'(locked), 64'd1);
    for (int i = 0; i < CD; i++) begin
      rd_idx = 2'(i);
      #1;
      check({req, " R8 snapshot word"}, cap_word, exp_w[i]);
      check({req, " periodic content"}, 64'(is_square(cap_word)), 64'(square));
    end
    if (!square) check("R10 true offset", 64'(off % 66), 64'd0);
    for (int i = 0; i < 3 * WL; i++) begin
      step(1'b1, lane_word(square, k, off), 1'b0);
      k++;
    end
    check({req, " R6 lock kept on clean stream"}, 64'(locked), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] pay [CD];
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // reset state, R9 and R7
    check("R9 reset locked", 64'(locked), 64'd0);
    check("R9 reset slip", 64'(slip), 64'd0);
    check("R9 reset done", 64'(cap_done), 64'd0);
    check("R7 ready high", 64'(in_ready), 64'd1);

    // R2 and R1: lock after exactly LR legal headers, idle illegal words ignored (R7)
    step(1'b0, '0, 1'b1);
    for (int i = 0; i < LR - 1; i++) begin
      step(1'b1, mk(good_hdr(i), 64'($urandom)), 1'b0);
      if (i == 5) begin
        step(1'b0, mk(2'b00, '0), 1'b0);
        check("R7 idle illegal no slip", 64'(slip), 64'd0);
      end
    end
    check("R2 not yet locked", 64'(locked), 64'd0);
    step(1'b1, mk(2'b10, 64'($urandom)), 1'b0);
    check("R2 lock at threshold", 64'(locked), 64'd1);

    // R8: snapshot of the next CD frames
    for (int i = 0; i < CD; i++) begin
      pay[i] = {$urandom, $urandom};
      if (i == 1) step(1'b0, mk(2'b01, '1), 1'b0);
      step(1'b1, mk(good_hdr(i), pay[i]), 1'b0);
      if (i < CD - 1) check("R8 done not early", 64'(cap_done), 64'd0);
    end
    check("R8 done rises", 64'(cap_done), 64'd1);
    for (int i = 0; i < 5; i++) step(1'b1, mk(2'b01, 64'($urandom)), 1'b0);
    for (int i = 0; i < CD; i++) begin
      rd_idx = 2'(i);
      #1;
      check("R9 held word", cap_word, pay[i]);
    end
    check("R9 done held", 64'(cap_done), 64'd1);

    // R6 and R5: window of WL frames from lock; 3+5 done, now 3 bad + 5 good
    step(1'b1, mk(2'b00, '0), 1'b0);
    step(1'b1, mk(2'b11, '0), 1'b0);
    step(1'b1, mk(2'b00, '0), 1'b0);
    check("R6 below limit", 64'(locked), 64'd1);
    for (int i = 0; i < 5; i++) step(1'b1, mk(2'b10, '0), 1'b0);
    for (int i = 0; i < BL - 1; i++) step(1'b1, mk(2'b11, '0), 1'b0);
    check("R6 count restarts at window", 64'(locked), 64'd1);
    check("R5 no slip while locked", 64'(slip), 64'd0);
    step(1'b1, mk(2'b00, '0), 1'b0);
    check("R5 lock lost", 64'(locked), 64'd0);

    // R3: illegal while hunting gives one slip pulse, no blanking after loss of lock
    step(1'b1, mk(2'b00, '0), 1'b0);
    check("R3 slip pulse", 64'(slip), 64'd1);
    // R4: the next BK frames are blanked even if illegal
    for (int i = 0; i < BK; i++) begin
      step(1'b1, mk(2'b11, '0), 1'b0);
      check("R4 blanked frame no slip", 64'(slip), 64'd0);
    end
    step(1'b1, mk(2'b00, '0), 1'b0);
    check("R4 checking resumes", 64'(slip), 64'd1);
    // R3: run restarts after an illegal header
    for (int i = 0; i < BK + 10; i++) step(1'b1, mk(2'b01, '0), 1'b0);
    step(1'b1, mk(2'b11, '0), 1'b0);
    check("R3 second slip", 64'(slip), 64'd1);
    step(1'b1, mk(2'b01, '0), 1'b0);
    check("R3 pulse single", 64'(slip), 64'd0);
    for (int i = 0; i < BK - 1; i++) step(1'b1, mk(2'b10, '0), 1'b0);
    for (int i = 0; i < LR - 1; i++) step(1'b1, mk(good_hdr(i), '0), 1'b0);
    check("R3 run restarted", 64'(locked), 64'd0);
    step(1'b1, mk(2'b01, '0), 1'b0);
    check("R2 relock", 64'(locked), 64'd1);

    // R8: re-arm clears done
    step(1'b0, '0, 1'b1);
    check("R8 arm clears done", 64'(cap_done), 64'd0);

    // R10: gearbox model with random gaps
    gear_run(1'b0, "R10 framed");
    gear_run(1'b1, "R10 square");

    do_reset();
    check("R9 reset clears done", 64'(cap_done), 64'd0);
    check("R9 reset clears lock", 64'(locked), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule